// File: doc/BRIEF.md
# Level/Edge Interrupt Source State Buffer

This block keeps the event state of a small array of interrupt sources and tells a downstream router which source has an event to deliver. Every source holds a two-bit pending/queued state. A static configuration bit makes each source either level-sensitive or edge/message type. Level-sensitive sources also hold an assertion flag that follows the input line. Line changes, software triggers and end-of-interrupt (EOI) requests move the state. When a move calls for delivery, the block raises a notification for that source.

Software reaches the block through a one-request-per-cycle register port. The address selects a source and a page. An even page (address bit 0 = 0) is a trigger page. An odd page (bit 0 = 1) is a management page, where an operation code selects EOI, state read or state write. Notifications leave through a valid/ready handshake that carries the source number. Requests that arrive together are merged per source and served lowest source number first.

Top module: `irq_src_state`

## Requirements
- R1: Synchronous reset puts every source's state to 01 (off) and clears every assertion flag and every pending notification. The level/edge type comes from the `cfg_level` port, so a reset does not change it. After reset the type is still in force: an EOI on a level source whose line is high re-notifies.
- R2: The state field is {P,Q}, with P in bit 1 and Q in bit 0. The values are 00 idle, 10 pending, 11 pending with a queued event, and 01 off. The management GET operation (`req_op` = 01) returns the state in `rsp_data` and leaves it unchanged.
- R3: For an edge-type source, only a low-to-high change of its line counts as a trigger. The trigger moves 00 to 10 and notifies; it moves 10 to 11, leaves 11 at 11 and leaves 01 at 01, all without a notification. A falling or steady line has no effect.
- R4: A request to a trigger page applies the R3 trigger to an edge-type source, whatever `req_op` holds. It has no effect on a level source. Its response data is 00.
- R5: For a level source, any change of its line copies the line into the assertion flag. If the line is now high and the state is 00, the state becomes 10 and a notification is issued. Otherwise the state does not change.
- R6: A level source never holds Q = 1. A SET on a level source stores wdata[1] as P and 0 as Q.
- R7: EOI (`req_op` = 00 on a management page) leaves state 01 unchanged and responds 00. From 11 it moves to 10, notifies and responds 01. From 10 it moves to 00 and responds 00. If the source is level type and still asserted, it instead moves on to 10, notifies and responds 01.
- R8: SET (`req_op` = 10) writes `req_wdata` into the state and responds with the previous state. Code 11 changes nothing and responds 00.
- R9: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, with `rsp_data` valid alongside it.
- R10: `ntf_valid` is high in the cycle after an event while any notification is waiting. `ntf_src` names the lowest-numbered waiting source. A notification stays presented until it is accepted with `ntf_ready`. Several notifications for one source before acceptance merge into one.
- R11: When a line change and a management request hit the same source in one cycle, the line change is applied first. The request then acts on the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_level | input | N | Per-source type: 1 level-sensitive, 0 edge/message; held static |
| src_line | input | N | Synchronous interrupt input lines |
| req_valid | input | 1 | Register request strobe |
| req_addr | input | SRC_W+1 | {source number, page bit}; page bit 0 trigger, 1 management |
| req_op | input | 2 | Management op: 00 EOI, 01 GET, 10 SET, 11 none |
| req_wdata | input | 2 | State value for SET |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_data | output | 2 | Response value |
| ntf_valid | output | 1 | A notification is presented |
| ntf_ready | input | 1 | Router accepts the presented notification |
| ntf_src | output | SRC_W | Source number of the presented notification |

## Verification
Two functions can meet in one cycle on one source: a rising level line and an EOI. The bench provokes this by driving both in the same cycle to a level source that is idle. The expected result follows from the line-first rule: the line fires, the EOI returns the state to idle, and the still-high flag fires again. So the response must read 01, exactly one merged notification must appear for that source, and a later GET must read 10. A second collision comes from two sources notifying in one cycle while the router stalls. There the bench checks that the lower number is presented and held, and that the higher one follows after acceptance.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  typedef enum logic [1:0] {
    OP_EOI = 2'b00,
    OP_GET = 2'b01,
    OP_SET = 2'b10,
    OP_NOP = 2'b11
  } mgmt_op_e;

  localparam logic [1:0] PQ_IDLE   = 2'b00;
  localparam logic [1:0] PQ_OFF    = 2'b01;
  localparam logic [1:0] PQ_PEND   = 2'b10;
  localparam logic [1:0] PQ_QUEUED = 2'b11;

  typedef struct packed {
    logic [1:0] pq;
    logic       fire;
  } step_t;

  // Edge-type trigger: idle fires, pending queues, queued and off hold.
  function automatic step_t edge_step(input logic [1:0] pq);
    step_t r;
    case (pq)
      PQ_IDLE: r = '{pq: PQ_PEND,   fire: 1'b1};
      PQ_PEND: r = '{pq: PQ_QUEUED, fire: 1'b0};
      default: r = '{pq: pq,        fire: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_src_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       is_level,
  input  logic       line,
  input  logic       sel,
  input  logic       sel_trig,
  input  mgmt_op_e   op,
  input  logic [1:0] wdata,
  output logic       fire,
  output logic [1:0] rsp,
  output logic [1:0] pq
);

  logic [1:0] pq_q, pq_a, pq_n;
  logic       flag_q, flag_n;
  logic       fire_a, fire_b;
  step_t      st_line, st_sw;

  always_comb begin
    // Stage 1: line event (applied before any request, R11)
    flag_n  = line;
    pq_a    = pq_q;
    fire_a  = 1'b0;
    st_line = edge_step(pq_q);
    if (line != flag_q) begin
      if (is_level) begin
        if (line && pq_q == PQ_IDLE) begin
          pq_a   = PQ_PEND;
          fire_a = 1'b1;
        end
      end else if (line) begin
        pq_a   = st_line.pq;
        fire_a = st_line.fire;
      end
    end

    // Stage 2: register request on the post-line state
    pq_n   = pq_a;
    fire_b = 1'b0;
    rsp    = 2'b00;
    st_sw  = edge_step(pq_a);
    if (sel) begin
      if (sel_trig) begin
        if (!is_level) begin
          pq_n   = st_sw.pq;
          fire_b = st_sw.fire;
        end
      end else begin
        case (op)
          OP_EOI: begin
            if (pq_a != PQ_OFF) begin
              if (pq_a[0]) begin
                pq_n   = PQ_PEND;
                fire_b = 1'b1;
              end else if (is_level && flag_n) begin
                pq_n   = PQ_PEND;
                fire_b = 1'b1;
              end else begin
                pq_n = PQ_IDLE;
              end
            end
            rsp = {1'b0, fire_b};
          end
          OP_GET: rsp = pq_a;
          OP_SET: begin
            rsp  = pq_a;
            pq_n = is_level ? {wdata[1], 1'b0} : wdata;
          end
          default: rsp = 2'b00;
        endcase
      end
    end
    fire = fire_a | fire_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pq_q   <= PQ_OFF;
      flag_q <= 1'b0;
    end else begin
      pq_q   <= pq_n;
      flag_q <= flag_n;
    end
  end

  assign pq = pq_q;

endmodule

// File: rtl/irq_src_arb.sv
module irq_src_arb #(
  parameter int N = 8,
  localparam int SRC_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     fire,
  input  logic             ready,
  output logic             valid,
  output logic [SRC_W-1:0] src
);

  logic [N-1:0] pend_q, grant;

  always_comb begin
    valid = |pend_q;
    src   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) src = SRC_W'(i);
    end
    grant = '0;
    if (valid && ready) grant[src] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~grant) | fire;
  end

endmodule

// File: rtl/irq_src_state.sv
module irq_src_state
  import irq_src_pkg::*;
#(
  parameter int N = 8,
  localparam int SRC_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     cfg_level,
  input  logic [N-1:0]     src_line,
  input  logic             req_valid,
  input  logic [SRC_W:0]   req_addr,
  input  logic [1:0]       req_op,
  input  logic [1:0]       req_wdata,
  output logic             rsp_valid,
  output logic [1:0]       rsp_data,
  output logic             ntf_valid,
  input  logic             ntf_ready,
  output logic [SRC_W-1:0] ntf_src
);

  logic [SRC_W-1:0] req_idx;
  logic             req_trig;
  mgmt_op_e         op;
  logic [N-1:0]     fire;
  logic [1:0]       cell_rsp [N];
  logic [2*N-1:0]   pq_all;
  logic [1:0]       rsp_mux;

  assign req_idx  = req_addr[SRC_W:1];
  assign req_trig = ~req_addr[0];
  assign op       = mgmt_op_e'(req_op);

  for (genvar i = 0; i < N; i++) begin : g_src
    irq_src_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .is_level (cfg_level[i]),
      .line     (src_line[i]),
      .sel      (req_valid && (req_idx == SRC_W'(i))),
      .sel_trig (req_trig),
      .op       (op),
      .wdata    (req_wdata),
      .fire     (fire[i]),
      .rsp      (cell_rsp[i]),
      .pq       (pq_all[2*i +: 2])
    );
  end

  always_comb begin
    rsp_mux = 2'b00;
    for (int i = 0; i < N; i++) rsp_mux = rsp_mux | cell_rsp[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 2'b00;
    end else begin
      rsp_valid <= req_valid;
      rsp_data  <= rsp_mux;
    end
  end

  irq_src_arb #(.N(N)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .ready (ntf_ready),
    .valid (ntf_valid),
    .src   (ntf_src)
  );

endmodule

// File: rtl/irq_src_state_chk.sv
module irq_src_state_chk #(
  parameter int N = 8,
  localparam int SRC_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     cfg_level,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             ntf_valid,
  input logic             ntf_ready,
  input logic [SRC_W-1:0] ntf_src,
  input logic [2*N-1:0]   pq_all
);

  logic [N-1:0] q_bits;
  always_comb begin
    for (int i = 0; i < N; i++) q_bits[i] = pq_all[2*i];
  end

  AST_RESET_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pq_all == {N{2'b01}})) else $error("reset state"); // R1
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ntf_valid && !rsp_valid)) else $error("quiet after reset"); // R1
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid) else $error("missing response"); // R9
  AST_RSP_ONLY: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid) else $error("spurious response"); // R9
  AST_LEVEL_NO_Q: assert property (@(posedge clk) disable iff (rst)
    (!(|(cfg_level & q_bits)) && $stable(cfg_level)) |=> !(|(cfg_level & q_bits)))
    else $error("level source holds Q"); // R6
  AST_NTF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ntf_valid && !ntf_ready) |=> ntf_valid) else $error("notification dropped"); // R10
  AST_NTF_RANGE: assert property (@(posedge clk) disable iff (rst)
    ntf_valid |-> (int'(ntf_src) < N)) else $error("source out of range"); // R10

endmodule

bind irq_src_state irq_src_state_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_level (cfg_level),
  .req_valid (req_valid),
  .rsp_valid (rsp_valid),
  .ntf_valid (ntf_valid),
  .ntf_ready (ntf_ready),
  .ntf_src   (ntf_src),
  .pq_all    (pq_all)
);

// File: tb/irq_src_state_tb.sv
`timescale 1ns/1ps
module irq_src_state_tb;

  localparam int N = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  cfg_level = 8'hF0;   // sources 4..7 level, 0..3 edge
  logic [N-1:0]  src_line = '0;
  logic          req_valid = 1'b0;
  logic [SW:0]   req_addr = '0;
  logic [1:0]    req_op = 2'b00;
  logic [1:0]    req_wdata = 2'b00;
  logic          rsp_valid, ntf_valid;
  logic [1:0]    rsp_data;
  logic          ntf_ready = 1'b1;
  logic [SW-1:0] ntf_src;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_src_state #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .cfg_level(cfg_level), .src_line(src_line),
    .req_valid(req_valid), .req_addr(req_addr), .req_op(req_op),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_src(ntf_src)
  );

  localparam logic [1:0] EOI = 2'b00, GET = 2'b01, SET = 2'b10, NOP = 2'b11;

  typedef struct packed {
    logic [3:0] rid;
    logic [2:0] src;
    logic       setl;
    logic       lval;
    logic       req;
    logic       mgmt;
    logic [1:0] op;
    logic [1:0] wd;
    logic [1:0] ersp;
    logic       entf;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, GET, 2'b00, 2'b01, 1'b0}, // R2 off after reset
    '{4'd8,  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, SET, 2'b00, 2'b01, 1'b0}, // R8 set idle
    '{4'd3,  3'd0, 1'b1, 1'b1, 1'b0, 1'b1, GET, 2'b00, 2'b00, 1'b1}, // R3 rise 00->10
    '{4'd2,  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, GET, 2'b00, 2'b10, 1'b0},
    '{4'd3,  3'd0, 1'b1, 1'b0, 1'b0, 1'b1, GET, 2'b00, 2'b00, 1'b0}, // R3 fall ignored
    '{4'd3,  3'd0, 1'b1, 1'b1, 1'b0, 1'b1, GET, 2'b00, 2'b00, 1'b0}, // R3 10->11
    '{4'd2,  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, GET, 2'b00, 2'b11, 1'b0},
    '{4'd4,  3'd0, 1'b0, 1'b0, 1'b1, 1'b0, GET, 2'b00, 2'b00, 1'b0}, // R4 11 stays
    '{4'd7,  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, EOI, 2'b00, 2'b01, 1'b1}, // R7 11->10 notify
    '{4'd2,  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, GET, 2'b00, 2'b10, 1'b0},
    '{4'd7,  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, EOI, 2'b00, 2'b00, 1'b0}, // R7 10->00
    '{4'd4,  3'd0, 1'b0, 1'b0, 1'b1, 1'b0, SET, 2'b00, 2'b00, 1'b1}, // R4 trigger page 00->10
    '{4'd7,  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, EOI, 2'b00, 2'b00, 1'b0},
    '{4'd8,  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, SET, 2'b01, 2'b00, 1'b0}, // R8 set off
    '{4'd4,  3'd0, 1'b0, 1'b0, 1'b1, 1'b0, EOI, 2'b00, 2'b00, 1'b0}, // R4 off ignores trigger
    '{4'd7,  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, EOI, 2'b00, 2'b00, 1'b0}, // R7 off unaffected
    '{4'd8,  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, NOP, 2'b00, 2'b00, 1'b0}, // R8 code 11
    '{4'd2,  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, GET, 2'b00, 2'b01, 1'b0},
    '{4'd8,  3'd4, 1'b0, 1'b0, 1'b1, 1'b1, SET, 2'b00, 2'b01, 1'b0},
    '{4'd5,  3'd4, 1'b1, 1'b1, 1'b0, 1'b1, GET, 2'b00, 2'b00, 1'b1}, // R5 level rise fires
    '{4'd5,  3'd4, 1'b1, 1'b0, 1'b0, 1'b1, GET, 2'b00, 2'b00, 1'b0}, // R5 fall: no change
    '{4'd2,  3'd4, 1'b0, 1'b0, 1'b1, 1'b1, GET, 2'b00, 2'b10, 1'b0},
    '{4'd7,  3'd4, 1'b0, 1'b0, 1'b1, 1'b1, EOI, 2'b00, 2'b00, 1'b0}, // R7 deasserted -> 00
    '{4'd5,  3'd4, 1'b1, 1'b1, 1'b0, 1'b1, GET, 2'b00, 2'b00, 1'b1},
    '{4'd7,  3'd4, 1'b0, 1'b0, 1'b1, 1'b1, EOI, 2'b00, 2'b01, 1'b1}, // R7 still asserted
    '{4'd4,  3'd4, 1'b0, 1'b0, 1'b1, 1'b0, GET, 2'b00, 2'b00, 1'b0}, // R4 level ignores
    '{4'd6,  3'd4, 1'b0, 1'b0, 1'b1, 1'b1, SET, 2'b11, 2'b10, 1'b0}, // R6 Q masked
    '{4'd6,  3'd4, 1'b0, 1'b0, 1'b1, 1'b1, GET, 2'b00, 2'b10, 1'b0},
    '{4'd5,  3'd4, 1'b1, 1'b0, 1'b0, 1'b1, GET, 2'b00, 2'b00, 1'b0},
    '{4'd7,  3'd4, 1'b0, 1'b0, 1'b1, 1'b1, EOI, 2'b00, 2'b00, 1'b0},
    '{4'd2,  3'd4, 1'b0, 1'b0, 1'b1, 1'b1, GET, 2'b00, 2'b00, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, then sample 2 ns after the edge.
  task automatic step(input logic [2:0] s, input logic setl, input logic lval,
                      input logic req, input logic mgmt, input logic [1:0] op,
                      input logic [1:0] wd);
    @(negedge clk);
    if (setl) src_line[s] = lval;
    req_valid = req;
    req_addr  = {s, mgmt};
    req_op    = op;
    req_wdata = wd;
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    step(3'd0, 1'b0, 1'b0, 1'b0, 1'b1, NOP, 2'b00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #2;
    chk("R1 ntf_valid after reset", int'(ntf_valid), 0);
    chk("R1 rsp_valid after reset", int'(rsp_valid), 0);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k].src, VEC[k].setl, VEC[k].lval, VEC[k].req, VEC[k].mgmt,
           VEC[k].op, VEC[k].wd);
      chk($sformatf("R9 vec %0d rsp_valid", k), int'(rsp_valid), int'(VEC[k].req));
      if (VEC[k].req)
        chk($sformatf("R%0d vec %0d rsp_data", VEC[k].rid, k), int'(rsp_data), int'(VEC[k].ersp));
      chk($sformatf("R%0d vec %0d ntf_valid", VEC[k].rid, k), int'(ntf_valid), int'(VEC[k].entf));
      if (VEC[k].entf)
        chk($sformatf("R10 vec %0d ntf_src", k), int'(ntf_src), int'(VEC[k].src));
    end

    // R10: two sources fire together, router stalled
    ntf_ready = 1'b0;
    step(3'd1, 1'b0, 1'b0, 1'b1, 1'b1, SET, 2'b00);
    step(3'd2, 1'b0, 1'b0, 1'b1, 1'b1, SET, 2'b00);
    @(negedge clk);
    src_line[1] = 1'b1;
    src_line[2] = 1'b1;
    req_valid = 1'b0;
    @(posedge clk); #2;
    chk("R10 lowest first valid", int'(ntf_valid), 1);
    chk("R10 lowest first src", int'(ntf_src), 1);
    idle();
    chk("R10 held while stalled", int'(ntf_src), 1);
    @(negedge clk) ntf_ready = 1'b1;
    @(posedge clk); #2;
    chk("R10 next after accept", int'(ntf_src), 2);
    chk("R10 next valid", int'(ntf_valid), 1);
    idle();
    chk("R10 drained", int'(ntf_valid), 0);

    // R11: level rise and EOI on the same source in one cycle
    step(3'd5, 1'b0, 1'b0, 1'b1, 1'b1, SET, 2'b00);
    step(3'd5, 1'b1, 1'b1, 1'b1, 1'b1, EOI, 2'b00);
    chk("R11 EOI response", int'(rsp_data), 1);
    chk("R11 ntf_valid", int'(ntf_valid), 1);
    chk("R11 ntf_src", int'(ntf_src), 5);
    idle();
    chk("R10 merged into one", int'(ntf_valid), 0);
    step(3'd5, 1'b0, 1'b0, 1'b1, 1'b1, GET, 2'b00);
    chk("R11 state after collision", int'(rsp_data), 2);

    // R1: reset mid-run with line 5 high; type must survive
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #2;
    chk("R1 ntf cleared", int'(ntf_valid), 0);
    step(3'd5, 1'b0, 1'b0, 1'b1, 1'b1, GET, 2'b00);
    chk("R1 state off", int'(rsp_data), 1);
    step(3'd5, 1'b0, 1'b0, 1'b1, 1'b1, SET, 2'b00);
    chk("R5 set idle no fire", int'(ntf_valid), 0);
    step(3'd5, 1'b0, 1'b0, 1'b1, 1'b1, EOI, 2'b00);
    chk("R1 level type kept rsp", int'(rsp_data), 1);
    chk("R1 level type kept ntf", int'(ntf_valid), 1);
    chk("R1 level type kept src", int'(ntf_src), 5);
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule